// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a calendar clock that counts time of day and date in packed BCD. A free-running enable pulse at 32.768 kHz drives a prescaler. After a set number of pulses the seconds field advances, and carries ripple through minutes, hours, day, month and a two-digit year counted from 2000. A weekday counter runs alongside the day. Six alarm byte registers shadow seconds through year. When all six match the time just after an update, a sticky alarm flag is raised. The flag can drive an interrupt line through an enable bit.

Software reaches every field over a single-cycle byte bus. A status bit marks the last prescaler period of each second, the only window in which an update can land. Software that sees the bit low has at least one prescaler period to read or rewrite the time without stopping the clock. Only 24-hour time is kept.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, every time and alarm byte reads 0x00, except day (0x0C) and month (0x10), which read 0x01. Control (0x40), status (0x44) and interrupt enable (0x48) read 0x00, and `alarm_irq` is low.
- R2: Bit 0 of control at 0x40 is the run bit. While it is 0, tick pulses change neither the prescaler nor any time byte.
- R3: While running, the seconds byte (0x00) advances by one BCD count on every TICKS_PER_SEC-th tick pulse.
- R4: Status bit 0 at 0x44 is high exactly while the clock is running and the prescaler sits in its final period before the seconds update. It falls with the updating tick.
- R5: Seconds and minutes wrap from 0x59 to 0x00 and hours from 0x23 to 0x00, each carrying into the next field. The hour wrap also advances the weekday (0x18), which runs 0 to 6 and wraps to 0.
- R6: Day (0x0C) wraps to 0x01 after the last day of its month (30 for April, June, September and November; 28, or 29 when the year is divisible by 4, for February; 31 otherwise) and carries into the month. Month (0x10) wraps from 0x12 to 0x01 and carries into the year (0x14), which wraps from 0x99 to 0x00.
- R7: The time bytes 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and the alarm bytes 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 read back what was written. The weekday keeps only bits 3:0; bits 7:4 read 0.
- R8: A bus write to a time byte in the same cycle as a seconds update stores the written value in that byte. Every other byte takes its updated value, computed from the time as it was before the write.
- R9: Status bit 6 sets in the cycle after an update that leaves seconds through year equal to the six alarm bytes. It stays set until a status write with bit 6 = 1; a status write with bit 6 = 0 leaves it set.
- R10: `alarm_irq` is high exactly when status bit 6 is set and bit 3 of 0x48 is 1.
- R11: Reads of any other offset return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read access |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
Both a software write to a time byte and the once-per-second update can change the same registers, and both can fall on one clock edge. The bench counts prescaler periods to reach the busy window. It then raises the tick pulse together with a write to seconds or to minutes. The result is judged against a model that first applies the update to the old time, including a carry out of 59 seconds, and then overwrites the written field. Randomly placed dates near month, year and leap boundaries, followed by random tick bursts, cover the rollover chain.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          alarm_irq
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PMAX = PW'(TICKS_PER_SEC - 1);

  localparam logic [AW-1:0] O_SEC  = AW'(8'h00);
  localparam logic [AW-1:0] O_MIN  = AW'(8'h04);
  localparam logic [AW-1:0] O_HR   = AW'(8'h08);
  localparam logic [AW-1:0] O_DAY  = AW'(8'h0C);
  localparam logic [AW-1:0] O_MON  = AW'(8'h10);
  localparam logic [AW-1:0] O_YR   = AW'(8'h14);
  localparam logic [AW-1:0] O_WK   = AW'(8'h18);
  localparam logic [AW-1:0] O_ASEC = AW'(8'h20);
  localparam logic [AW-1:0] O_AMIN = AW'(8'h24);
  localparam logic [AW-1:0] O_AHR  = AW'(8'h28);
  localparam logic [AW-1:0] O_ADAY = AW'(8'h2C);
  localparam logic [AW-1:0] O_AMON = AW'(8'h30);
  localparam logic [AW-1:0] O_AYR  = AW'(8'h34);
  localparam logic [AW-1:0] O_CTL  = AW'(8'h40);
  localparam logic [AW-1:0] O_STAT = AW'(8'h44);
  localparam logic [AW-1:0] O_IEN  = AW'(8'h48);

  logic [7:0] sec_q, min_q, hr_q, day_q, mon_q, yr_q;
  logic [3:0] wk_q;
  logic [7:0] asec_q, amin_q, ahr_q, aday_q, amon_q, ayr_q;
  logic       run_q, ien_q, flag_q, upd_q;
  logic [PW-1:0] presc_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    case (m)
      8'h02: return (s[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  wire wr = bus_sel & bus_wr;
  wire rd = bus_sel & ~bus_wr;

  wire w_sec  = wr && bus_addr == O_SEC;
  wire w_min  = wr && bus_addr == O_MIN;
  wire w_hr   = wr && bus_addr == O_HR;
  wire w_day  = wr && bus_addr == O_DAY;
  wire w_mon  = wr && bus_addr == O_MON;
  wire w_yr   = wr && bus_addr == O_YR;
  wire w_wk   = wr && bus_addr == O_WK;
  wire w_ctl  = wr && bus_addr == O_CTL;
  wire w_stat = wr && bus_addr == O_STAT;
  wire w_ien  = wr && bus_addr == O_IEN;

  wire busy = run_q && presc_q == PMAX;
  wire upd  = busy && tick_en;

  wire c_sec = sec_q >= 8'h59;
  wire c_min = c_sec && min_q >= 8'h59;
  wire c_hr  = c_min && hr_q >= 8'h23;
  wire c_day = c_hr && day_q >= month_end(mon_q, yr_q);
  wire c_mon = c_day && mon_q >= 8'h12;

  wire [7:0] n_sec = c_sec ? 8'h00 : bcd_inc(sec_q);
  wire [7:0] n_min = (min_q >= 8'h59) ? 8'h00 : bcd_inc(min_q);
  wire [7:0] n_hr  = (hr_q >= 8'h23) ? 8'h00 : bcd_inc(hr_q);
  wire [7:0] n_day = c_day ? 8'h01 : bcd_inc(day_q);
  wire [7:0] n_mon = c_mon ? 8'h01 : bcd_inc(mon_q);
  wire [7:0] n_yr  = (yr_q >= 8'h99) ? 8'h00 : bcd_inc(yr_q);
  wire [3:0] n_wk  = (wk_q >= 4'd6) ? 4'd0 : wk_q + 4'd1;

  wire match = sec_q == asec_q && min_q == amin_q && hr_q == ahr_q &&
               day_q == aday_q && mon_q == amon_q && yr_q == ayr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else if (run_q && tick_en) presc_q <= (presc_q == PMAX) ? '0 : presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      day_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00; wk_q <= 4'd0;
    end else begin
      if (w_sec) sec_q <= bus_wdata;
      else if (upd) sec_q <= n_sec;
      if (w_min) min_q <= bus_wdata;
      else if (upd && c_sec) min_q <= n_min;
      if (w_hr) hr_q <= bus_wdata;
      else if (upd && c_min) hr_q <= n_hr;
      if (w_day) day_q <= bus_wdata;
      else if (upd && c_hr) day_q <= n_day;
      if (w_wk) wk_q <= bus_wdata[3:0];
      else if (upd && c_hr) wk_q <= n_wk;
      if (w_mon) mon_q <= bus_wdata;
      else if (upd && c_day) mon_q <= n_mon;
      if (w_yr) yr_q <= bus_wdata;
      else if (upd && c_mon) yr_q <= n_yr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asec_q <= '0; amin_q <= '0; ahr_q <= '0;
      aday_q <= '0; amon_q <= '0; ayr_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        O_ASEC: asec_q <= bus_wdata;
        O_AMIN: amin_q <= bus_wdata;
        O_AHR:  ahr_q  <= bus_wdata;
        O_ADAY: aday_q <= bus_wdata;
        O_AMON: amon_q <= bus_wdata;
        O_AYR:  ayr_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; ien_q <= 1'b0; flag_q <= 1'b0; upd_q <= 1'b0;
    end else begin
      upd_q <= upd;
      if (w_ctl) run_q <= bus_wdata[0];
      if (w_ien) ien_q <= bus_wdata[3];
      if (upd_q && match) flag_q <= 1'b1;
      else if (w_stat && bus_wdata[6]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (rd) begin
      case (bus_addr)
        O_SEC:  bus_rdata = sec_q;
        O_MIN:  bus_rdata = min_q;
        O_HR:   bus_rdata = hr_q;
        O_DAY:  bus_rdata = day_q;
        O_MON:  bus_rdata = mon_q;
        O_YR:   bus_rdata = yr_q;
        O_WK:   bus_rdata = {4'd0, wk_q};
        O_ASEC: bus_rdata = asec_q;
        O_AMIN: bus_rdata = amin_q;
        O_AHR:  bus_rdata = ahr_q;
        O_ADAY: bus_rdata = aday_q;
        O_AMON: bus_rdata = amon_q;
        O_AYR:  bus_rdata = ayr_q;
        O_CTL:  bus_rdata = {7'd0, run_q};
        O_STAT: bus_rdata = {1'b0, flag_q, 5'd0, busy};
        O_IEN:  bus_rdata = {4'd0, ien_q, 3'd0};
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  assign alarm_irq = flag_q & ien_q;
endmodule

module bcd_rtc_chk #(
  parameter int TPS = 32768,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          wr_any,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic          run,
  input logic          busy,
  input logic          upd_d,
  input logic          flag,
  input logic [7:0]    sec,
  input logic [51:0]   tvec
);
  p_frozen_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_any) |=> $stable(tvec));

  p_sec_moves_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sec) && !$past(wr_any)) |-> $past(busy && tick_en));

  p_busy_single_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (TPS > 1 && busy && tick_en && !wr_any) |=> !busy);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_any && addr == AW'(8'h44) && wdata[6])) |=> flag);

  p_flag_after_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(upd_d));
endmodule

bind bcd_rtc bcd_rtc_chk #(.TPS(TICKS_PER_SEC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_any(wr), .addr(bus_addr),
  .wdata(bus_wdata), .run(run_q), .busy(busy), .upd_d(upd_q), .flag(flag_q),
  .sec(sec_q), .tvec({sec_q, min_q, hr_q, day_q, mon_q, yr_q, wk_q})
);

// File: tb/bcd_rtc_bench.sv
module bcd_rtc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic alarm_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wk, m_presc;
  int a_sec, a_min, a_hr, a_day, a_mon, a_yr;
  bit m_run, m_flag, m_ie;

  bcd_rtc #(.TICKS_PER_SEC(TPS), .AW(8)) u_bcd_rtc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] to_bcd(input int b);
    return 8'((b / 10) * 16 + (b % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic model_second();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0; m_wk = (m_wk >= 6) ? 0 : m_wk + 1;
          m_day++;
          if (m_day > days_in(m_mon, m_yr)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_yr = (m_yr == 99) ? 0 : m_yr + 1;
            end
          end
        end
      end
    end
    if (m_sec == a_sec && m_min == a_min && m_hr == a_hr && m_day == a_day &&
        m_mon == a_mon && m_yr == a_yr) m_flag = 1;
  endtask

  task automatic model_tick();
    if (m_run) begin
      if (m_presc == TPS - 1) begin m_presc = 0; model_second(); end
      else m_presc++;
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h00: m_sec = from_bcd(d);
      8'h04: m_min = from_bcd(d);
      8'h08: m_hr  = from_bcd(d);
      8'h0C: m_day = from_bcd(d);
      8'h10: m_mon = from_bcd(d);
      8'h14: m_yr  = from_bcd(d);
      8'h18: m_wk  = int'(d[3:0]);
      8'h20: a_sec = from_bcd(d);
      8'h24: a_min = from_bcd(d);
      8'h28: a_hr  = from_bcd(d);
      8'h2C: a_day = from_bcd(d);
      8'h30: a_mon = from_bcd(d);
      8'h34: a_yr  = from_bcd(d);
      8'h40: m_run = d[0];
      8'h44: if (d[6]) m_flag = 0;
      8'h48: m_ie = d[3];
      default: ;
    endcase
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    model_tick();
  endtask

  task automatic tick_and_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    model_tick();
    model_write(a, d);
  endtask

  task automatic advance_sec();
    do tick(); while (m_presc != 0);
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic check_time(input string req);
    expect_reg(req, 8'h00, to_bcd(m_sec));
    expect_reg(req, 8'h04, to_bcd(m_min));
    expect_reg(req, 8'h08, to_bcd(m_hr));
    expect_reg(req, 8'h0C, to_bcd(m_day));
    expect_reg(req, 8'h10, to_bcd(m_mon));
    expect_reg(req, 8'h14, to_bcd(m_yr));
    expect_reg(req, 8'h18, 8'(m_wk));
  endtask

  task automatic status_exp(output logic [7:0] s);
    s = {1'b0, m_flag, 5'd0, (m_run && m_presc == TPS - 1)};
  endtask

  task automatic set_time(input int yr, input int mon, input int day, input int hr,
                          input int mn, input int sc, input int wk);
    bus_write(8'h14, to_bcd(yr)); bus_write(8'h10, to_bcd(mon));
    bus_write(8'h0C, to_bcd(day)); bus_write(8'h08, to_bcd(hr));
    bus_write(8'h04, to_bcd(mn)); bus_write(8'h00, to_bcd(sc));
    bus_write(8'h18, 8'(wk));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_wk = 0; m_presc = 0;
    a_sec = 0; a_min = 0; a_hr = 0; a_day = 0; a_mon = 0; a_yr = 0;
    m_run = 0; m_flag = 0; m_ie = 0;
    void'($urandom(32'd20061));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_time("R1");
    expect_reg("R1", 8'h20, 8'h00); expect_reg("R1", 8'h24, 8'h00);
    expect_reg("R1", 8'h28, 8'h00); expect_reg("R1", 8'h2C, 8'h00);
    expect_reg("R1", 8'h30, 8'h00); expect_reg("R1", 8'h34, 8'h00);
    expect_reg("R1", 8'h40, 8'h00); expect_reg("R1", 8'h44, 8'h00);
    expect_reg("R1", 8'h48, 8'h00);
    check("R1 irq", {7'd0, alarm_irq}, 8'h00);

    // R2 stopped clock ignores ticks
    repeat (TPS * 3) tick();
    check_time("R2");
    bus_write(8'h40, 8'h01);
    expect_reg("R2", 8'h40, 8'h01);

    // R4 busy in the last period, R3 seconds advance
    repeat (TPS - 1) tick();
    expect_reg("R4", 8'h44, 8'h01);
    expect_reg("R3", 8'h00, 8'h00);
    tick();
    expect_reg("R4", 8'h44, 8'h00);
    expect_reg("R3", 8'h00, 8'h01);
    repeat (TPS * 5) tick();
    expect_reg("R3", 8'h00, 8'h06);

    // R2 freeze mid-second
    tick();
    bus_write(8'h40, 8'h00);
    repeat (TPS * 4) tick();
    check_time("R2");
    expect_reg("R4", 8'h44, 8'h00);
    bus_write(8'h40, 8'h01);

    // R7 map and weekday width, R11 unmapped
    bus_write(8'h18, 8'hF5);
    expect_reg("R7", 8'h18, 8'h05);
    bus_write(8'h2C, 8'h17);
    expect_reg("R7", 8'h2C, 8'h17);
    bus_write(8'h2C, 8'h00);
    expect_reg("R11", 8'h1C, 8'h00);
    expect_reg("R11", 8'h3C, 8'h00);
    expect_reg("R11", 8'h80, 8'h00);

    // R5 cascade with weekday wrap and leap day
    set_time(24, 2, 28, 23, 59, 59, 6);
    advance_sec();
    check_time("R5");
    expect_reg("R5", 8'h0C, 8'h29);
    expect_reg("R5", 8'h18, 8'h00);
    // R6 month ends
    set_time(23, 2, 28, 23, 59, 59, 2);
    advance_sec();
    check_time("R6");
    expect_reg("R6", 8'h10, 8'h03);
    set_time(24, 2, 29, 23, 59, 59, 3);
    advance_sec();
    check_time("R6");
    set_time(31, 4, 30, 23, 59, 59, 1);
    advance_sec();
    check_time("R6");
    set_time(99, 12, 31, 23, 59, 59, 5);
    advance_sec();
    check_time("R6");
    expect_reg("R6", 8'h14, 8'h00);

    // R8 write lands in the update cycle
    set_time(10, 6, 15, 12, 10, 30, 1);
    while (m_presc != TPS - 1) tick();
    tick_and_write(8'h04, 8'h15);
    check_time("R8");
    expect_reg("R8", 8'h04, 8'h15);
    expect_reg("R8", 8'h00, 8'h31);
    set_time(10, 6, 15, 12, 10, 59, 1);
    while (m_presc != TPS - 1) tick();
    tick_and_write(8'h00, 8'h20);
    check_time("R8");
    expect_reg("R8", 8'h04, 8'h11);

    // R9 / R10 alarm
    set_time(33, 7, 4, 10, 20, 29, 2);
    bus_write(8'h34, 8'h33); bus_write(8'h30, 8'h07); bus_write(8'h2C, 8'h04);
    bus_write(8'h28, 8'h10); bus_write(8'h24, 8'h20); bus_write(8'h20, 8'h31);
    advance_sec();
    status_exp(s);
    expect_reg("R9 no match", 8'h44, s);
    advance_sec();
    status_exp(s);
    expect_reg("R9 set", 8'h44, s);
    check("R9 flag model", s & 8'h40, 8'h40);
    check("R10 gated", {7'd0, alarm_irq}, 8'h00);
    bus_write(8'h48, 8'h08);
    #1 check("R10 on", {7'd0, alarm_irq}, 8'h01);
    bus_write(8'h44, 8'h01);
    status_exp(s);
    expect_reg("R9 sticky", 8'h44, s);
    check("R10 still", {7'd0, alarm_irq}, 8'h01);
    bus_write(8'h44, 8'h40);
    status_exp(s);
    expect_reg("R9 clear", 8'h44, s);
    #1 check("R10 off", {7'd0, alarm_irq}, 8'h00);
    bus_write(8'h48, 8'h00);
    bus_write(8'h20, 8'h00); bus_write(8'h2C, 8'h00);

    // random dates near boundaries plus random tick bursts
    for (int it = 0; it < 60; it++) begin
      int yr, mon, day, hr, mn, sc, nt;
      yr  = $urandom_range(0, 99);
      mon = $urandom_range(1, 12);
      day = ($urandom_range(0, 1) == 1) ? days_in(mon, yr) : $urandom_range(1, days_in(mon, yr));
      hr  = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      mn  = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
      sc  = $urandom_range(55, 59);
      set_time(yr, mon, day, hr, mn, sc, $urandom_range(0, 6));
      nt = $urandom_range(0, TPS * 8);
      repeat (nt) tick();
      check_time((mon == 2) ? "R6" : "R5");
      status_exp(s);
      expect_reg("R4", 8'h44, s);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule